// File: doc/BRIEF.md
# Calibration Coefficient Transfer Sequencer

This block fills a volatile working coefficient store from a read-only factory store. It copies one word for each tick of a slow calibration timebase. The tick comes from a divider on the converter clock, and software chooses the divider's power-of-two ratio with a 3-bit select. Each tick produces one single-cycle write strobe, together with an address and a 6-bit coefficient. The working store, which sits outside this block, takes the word on that strobe.

A copy starts by itself when reset is released. Software can start another copy by raising and then lowering a transfer-enable input. When a copy finishes, a status flag goes high and a 2-bit memory-state field reports the factory-calibrated code. The factory store is a constant array inside the block. Its content is a fixed function of the address.

Top module: `cal_xfer_seq`

## Requirements
- R1: The gap between consecutive write strobes of one copy is exactly 2^(5+s) converter-clock cycles, where s is the latched 3-bit select. Code 000 gives /32, 001 gives /64, 110 gives /2048 and 111 gives /4096. Each strobe lasts one cycle and carries exactly one word.
- R2: After reset, a copy runs on its own at the reset select code 000. The value on `div_sel` during or after reset does not change the rate of that copy.
- R3: Each copy writes the addresses 1 to 132 in ascending order, each exactly once. The address is 8 bits wide. Addresses 1 to 127 are the major segments, 128 is the minor-bits sum, and 129 to 132 are the four gain trims.
- R4: The data word written at address a is the 6-bit factory value (a*29 + 5) mod 64.
- R5: A copy starts when `xfer_en` is sampled high on one clock edge and low on the next, while no copy is running. Its first strobe comes exactly 2^(5+s) cycles after that second edge. s is `div_sel` sampled on that edge.
- R6: `xfer_done` is 0 out of reset and while a copy runs, and it clears on the edge that starts a copy. It is 1 from the edge of the last strobe until the next start.
- R7: `mem_state` is 00 (uncalibrated) out of reset. It becomes 10 (factory-calibrated) on the edge that completes a copy and then holds.
- R8: A transfer-enable fall that is sampled while a copy runs is ignored, including one on the completing edge. The copy continues unchanged, and no new copy follows.
- R9: A change of `div_sel` during a copy does not alter that copy's strobe spacing. It only applies at the next start.
- R10: No write strobe occurs while no copy is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock |
| rst_n | input | 1 | Synchronous active-low reset; its release starts a copy |
| div_sel | input | 3 | Calibration-tick ratio select, 2^(5+div_sel) |
| xfer_en | input | 1 | Transfer-enable bit; a high-then-low sequence requests a copy |
| cal_wr_en | output | 1 | One-cycle write strobe into the working store |
| cal_wr_addr | output | 8 | Working-store address for the strobe (1 to 132) |
| cal_wr_data | output | 6 | Factory coefficient for that address |
| xfer_done | output | 1 | Copy-complete status |
| mem_state | output | 2 | Memory-state code: 00 uncalibrated, 10 factory-calibrated |

## Verification
Two events can fall on the same edge: a copy completing on its final tick, and a software transfer-enable fall that asks for a new copy. The bench raises `xfer_en` after strobe 131 and lowers it right after strobe 132 is observed, so the fall is sampled on the completing edge. It expects the request to be lost. `xfer_done` must stay 1 and no strobe may appear over a long idle window. A later, separate request must then start a normal copy. Random start points with random select changes during a copy check the same edge rule at arbitrary addresses.

// File: rtl/cal_xfer_pkg.sv
// Shared types and the factory coefficient function for the transfer sequencer.
// Assumes coefficients are 6 bits and the factory content is a pure function of address.
package cal_xfer_pkg;

    localparam int COEF_W = 6;

    typedef enum logic [1:0] {
        MS_UNCAL   = 2'b00,
        MS_SELF    = 2'b01,
        MS_FACTORY = 2'b10,
        MS_USER    = 2'b11
    } mem_state_e;

    // Factory coefficient for one address, reduced to the coefficient width.
    function automatic logic [COEF_W-1:0] factory_coef(input int unsigned addr);
        int unsigned v;
        v = (addr * 29 + 5) % (1 << COEF_W);
        return COEF_W'(v);
    endfunction

endpackage

// File: rtl/cal_clk_div.sv
// Calibration tick generator: emits a one-cycle enable every 2^(BASE_LOG2+sel)
// converter-clock cycles while run is high. It assumes sel is held stable by the caller
// during a run and that BASE_LOG2 >= 1, so ticks are never back to back.
module cal_clk_div #(
    parameter int BASE_LOG2 = 5,
    parameter int SEL_W     = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             restart,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    localparam int CNT_W = BASE_LOG2 + (1 << SEL_W) - 1;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W:0]   span;
    logic [CNT_W-1:0] lim_m1;

    // Divide ratio and terminal count for the current select.
    always_comb begin
        span   = (CNT_W+1)'(1) << (BASE_LOG2 + int'(sel));
        lim_m1 = CNT_W'(span - 1'b1);
    end

    assign tick = run && (cnt == lim_m1);

    // Cycle counter, cleared on start, idle or terminal count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (restart || !run || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    p_tick_spaced_r1: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

    p_cnt_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt <= lim_m1));

endmodule

// File: rtl/cal_factory_rom.sv
// Read-only factory coefficient store, built as a constant array from the package function.
// Entries below FIRST_ADDR and addresses past LAST_ADDR read as zero.
module cal_factory_rom #(
    parameter int ADDR_W     = 8,
    parameter int DATA_W     = 6,
    parameter int FIRST_ADDR = 1,
    parameter int LAST_ADDR  = 132
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] data
);
    import cal_xfer_pkg::*;

    logic [DATA_W-1:0] rom [0:LAST_ADDR];

    // One constant word per address.
    for (genvar i = 0; i <= LAST_ADDR; i++) begin : g_word
        if (i >= FIRST_ADDR) begin : g_used
            assign rom[i] = DATA_W'(factory_coef(i));
        end else begin : g_unused
            assign rom[i] = '0;
        end
    end

    // Guarded lookup.
    always_comb begin
        if (int'(addr) <= LAST_ADDR) data = rom[addr];
        else                         data = '0;
    end

endmodule

// File: rtl/cal_xfer_fsm.sv
// Copy sequencer: owns the busy state, the address walk, the latched divider select,
// the completion flag and the memory-state code. A copy is armed by reset and by a
// falling transfer-enable seen while idle. Requests during a copy are dropped.
module cal_xfer_fsm #(
    parameter int ADDR_W     = 8,
    parameter int SEL_W      = 3,
    parameter int FIRST_ADDR = 1,
    parameter int LAST_ADDR  = 132
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              xfer_en,
    input  logic [SEL_W-1:0]  div_sel,
    input  logic              tick,
    output logic              busy,
    output logic              start,
    output logic [SEL_W-1:0]  sel_q,
    output logic [ADDR_W-1:0] addr_q,
    output logic              done,
    output logic [1:0]        mem_state
);
    import cal_xfer_pkg::*;

    logic xfer_q;
    logic fall;
    logic last_word;

    assign fall      = xfer_q && !xfer_en;
    assign start     = fall && !busy;
    assign last_word = (addr_q == ADDR_W'(LAST_ADDR));

    // Sequencing state: auto-start out of reset, re-arm on an idle request, advance per tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            xfer_q    <= 1'b0;
            busy      <= 1'b1;
            addr_q    <= ADDR_W'(FIRST_ADDR);
            sel_q     <= '0;
            done      <= 1'b0;
            mem_state <= MS_UNCAL;
        end else begin
            xfer_q <= xfer_en;
            if (start) begin
                busy   <= 1'b1;
                addr_q <= ADDR_W'(FIRST_ADDR);
                sel_q  <= div_sel;
                done   <= 1'b0;
            end else if (tick) begin
                if (last_word) begin
                    busy      <= 1'b0;
                    done      <= 1'b1;
                    mem_state <= MS_FACTORY;
                end else begin
                    addr_q <= addr_q + 1'b1;
                end
            end
        end
    end

    p_done_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && busy));

    p_addr_walk_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !last_word) |=> (addr_q == $past(addr_q) + 1'b1));

    p_addr_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (addr_q >= ADDR_W'(FIRST_ADDR) && addr_q <= ADDR_W'(LAST_ADDR)));

    p_sel_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !start) |=> (sel_q == $past(sel_q)));

    p_state_on_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (mem_state == MS_FACTORY));

    p_ignore_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (fall && busy && !tick) |=> (busy && $stable(addr_q)));

    p_no_tick_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !tick);

endmodule

// File: rtl/cal_xfer_seq.sv
// Top of the calibration coefficient transfer sequencer: ties the divider, the copy
// sequencer and the factory store together and presents the working-store write port.
// Assumes the working store samples address and data on the cycle of the write strobe.
module cal_xfer_seq #(
    parameter int DIV_BASE_LOG2 = 5,
    parameter int SEL_W         = 3,
    parameter int ADDR_W        = 8,
    parameter int DATA_W        = 6,
    parameter int FIRST_ADDR    = 1,
    parameter int LAST_ADDR     = 132
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SEL_W-1:0]  div_sel,
    input  logic              xfer_en,
    output logic              cal_wr_en,
    output logic [ADDR_W-1:0] cal_wr_addr,
    output logic [DATA_W-1:0] cal_wr_data,
    output logic              xfer_done,
    output logic [1:0]        mem_state
);
    logic             tick;
    logic             busy;
    logic             start;
    logic [SEL_W-1:0] sel_q;

    cal_xfer_fsm #(
        .ADDR_W     (ADDR_W),
        .SEL_W      (SEL_W),
        .FIRST_ADDR (FIRST_ADDR),
        .LAST_ADDR  (LAST_ADDR)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .xfer_en   (xfer_en),
        .div_sel   (div_sel),
        .tick      (tick),
        .busy      (busy),
        .start     (start),
        .sel_q     (sel_q),
        .addr_q    (cal_wr_addr),
        .done      (xfer_done),
        .mem_state (mem_state)
    );

    cal_clk_div #(
        .BASE_LOG2 (DIV_BASE_LOG2),
        .SEL_W     (SEL_W)
    ) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (busy),
        .restart (start),
        .sel     (sel_q),
        .tick    (tick)
    );

    cal_factory_rom #(
        .ADDR_W     (ADDR_W),
        .DATA_W     (DATA_W),
        .FIRST_ADDR (FIRST_ADDR),
        .LAST_ADDR  (LAST_ADDR)
    ) u_rom (
        .addr (cal_wr_addr),
        .data (cal_wr_data)
    );

    assign cal_wr_en = tick;

    p_strobe_only_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cal_wr_en |-> !xfer_done);

endmodule

// File: tb/tb_cal_xfer_seq.sv
// Bench for the transfer sequencer. It uses a shorter base ratio (2^(1+sel)) to keep runs
// short, random selects and request points from a fixed seed, and directed corner cases.
module tb_cal_xfer_seq;

    localparam int B      = 1;
    localparam int LAST_A = 132;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [2:0] div_sel;
    logic       xfer_en;
    logic       cal_wr_en;
    logic [7:0] cal_wr_addr;
    logic [5:0] cal_wr_data;
    logic       xfer_done;
    logic [1:0] mem_state;

    int n_chk  = 0;
    int n_fail = 0;

    cal_xfer_seq #(.DIV_BASE_LOG2(B)) dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .div_sel     (div_sel),
        .xfer_en     (xfer_en),
        .cal_wr_en   (cal_wr_en),
        .cal_wr_addr (cal_wr_addr),
        .cal_wr_data (cal_wr_data),
        .xfer_done   (xfer_done),
        .mem_state   (mem_state)
    );

    always #4 clk = ~clk;

    function automatic int exp_coef(input int a);
        return (a * 29 + 5) % 64;
    endfunction

    function automatic int lim_of(input int s);
        return 1 << (B + s);
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Follow one copy to its end; optionally request a new copy during it (fall at strobe poke).
    task automatic watch_copy(input int lim, input bit sw_start, input int poke,
                              input logic [2:0] new_sel);
        int cyc  = 0;
        int last = 0;
        int n    = 0;
        while (n < LAST_A) begin
            @(negedge clk);
            cyc++;
            if (sw_start && cyc == 1)
                check(xfer_done == 1'b0, "R6", "done cleared on start", xfer_done, 0);
            if (cyc > lim * (LAST_A + 4)) begin
                check(1'b0, "R1", "copy timeout strobes", n, LAST_A);
                return;
            end
            if (cal_wr_en) begin
                n++;
                check(int'(cal_wr_addr) == n, "R3", "address order", cal_wr_addr, n);
                check(int'(cal_wr_data) == exp_coef(n), "R4", "factory data",
                      cal_wr_data, exp_coef(n));
                check(xfer_done == 1'b0, "R6", "done low during copy", xfer_done, 0);
                if (n == 1 && sw_start)
                    check(cyc == lim, "R5", "first strobe latency", cyc, lim);
                if (n > 1)
                    check(cyc - last == lim, "R1", "strobe gap", cyc - last, lim);
                last = cyc;
                if (poke >= 2 && n == poke - 1) begin
                    xfer_en = 1'b1;
                    div_sel = new_sel;
                end
                if (poke >= 2 && n == poke) xfer_en = 1'b0;
            end
        end
        @(negedge clk);
        check(xfer_done == 1'b1, "R6", "done after copy", xfer_done, 1);
        check(mem_state == 2'b10, "R7", "state factory", mem_state, 2);
        check(cal_wr_en == 1'b0, "R10", "no strobe after last", cal_wr_en, 0);
    endtask

    task automatic start_copy(input int s, input int poke, input logic [2:0] new_sel);
        @(negedge clk);
        div_sel = 3'(s);
        xfer_en = 1'b1;
        @(negedge clk);
        xfer_en = 1'b0;
        watch_copy(lim_of(s), 1'b1, poke, new_sel);
    endtask

    task automatic idle_check(input int cycles, input string req);
        int strobes = 0;
        int lows    = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (cal_wr_en) strobes++;
            if (!xfer_done) lows++;
        end
        check(strobes == 0, req, "strobes while idle", strobes, 0);
        check(lows == 0, req, "done dropped while idle", lows, 0);
    endtask

    task automatic finish_run();
        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // Watchdog.
    initial begin
        repeat (150000) @(negedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL R6 watchdog: cycles %0d expected below %0d", 150000, 150000);
        finish_run();
    end

    initial begin
        int s;
        int p;
        int ns;
        void'($urandom(32'd20240611));
        rst_n   = 1'b0;
        xfer_en = 1'b0;
        div_sel = 3'b101;
        repeat (5) @(negedge clk);
        check(cal_wr_en == 1'b0, "R10", "reset strobe", cal_wr_en, 0);
        check(xfer_done == 1'b0, "R6", "reset done", xfer_done, 0);
        check(mem_state == 2'b00, "R7", "reset state", mem_state, 0);
        rst_n = 1'b1;
        // R2: automatic copy at code 000 although div_sel holds 101.
        watch_copy(lim_of(0), 1'b0, 0, 3'b000);
        idle_check(40, "R10");
        // Slowest code.
        start_copy(7, 0, 3'b000);
        // R8/R9: request and select change in the middle of a fast copy.
        start_copy(0, 60, 3'b111);
        idle_check(20, "R8");
        for (int k = 0; k < 4; k++) begin
            s  = int'($urandom % 6);
            p  = 2 + int'($urandom % 130);
            ns = int'($urandom % 8);
            start_copy(s, p, 3'(ns));
            idle_check(3 * lim_of(s) + 4, "R8");
        end
        // R8 corner: request fall sampled on the completing edge.
        start_copy(2, LAST_A, 3'b011);
        idle_check(40, "R8");
        // A later request still starts a copy.
        start_copy(1, 0, 3'b000);
        finish_run();
    end

endmodule